// File: doc/BRIEF.md
# Stack Frame Entry Sequencer

This block performs the stack-frame setup at entry to a procedure in a block-structured language, on a 16-bit stack whose addresses count in bytes and hold 16-bit words. A single start pulse captures the frame size, the lexical nesting level and the caller's stack pointer (SP) and base pointer (BP). The block then works through its sequence of accesses on a request/ready memory port and returns the new SP and BP with a one-cycle done pulse.

The sequence begins by saving the caller's BP on the stack. The SP value after that push is kept as the new frame pointer. For a nesting level above zero, the block walks back through the caller's frame and copies the enclosing procedures' frame pointers into the new frame. It then pushes the new frame pointer. At nesting level zero there is no walk and no pointer push. Last, BP takes the frame pointer and SP drops by the frame size, which reserves room for locals.

Top module: `frame_entry_seq`

## Requirements
- R1: The first memory access after an accepted start is a write of the incoming BP to address SP_in-2.
- R2: For an effective level L>0, L-1 copy steps follow. Step k reads the word at BP_in-2k and writes it at SP_in-2-2k. Successive writes go to addresses that fall by 2 each time.
- R3: In each copy step the read completes, and its data is captured, before the write that stores it. The written word equals the word that read returned.
- R4: For L>0, the last write stores the frame pointer SP_in-2 at address SP_in-2-2L.
- R5: For L=0, the block makes exactly one write (the old BP) and no read.
- R6: When done is high, bp_out equals SP_in-2.
- R7: When done is high, sp_out equals SP_in - 2*P - frame_size modulo 2^16. P is the push count, 1 when L=0 and L+1 otherwise. Addresses wrap modulo 2^16.
- R8: Only the low 5 bits of the 8-bit level input are used, so L = level mod 32. A level of 32 behaves as 0 and 33 behaves as 1.
- R9: While mem_req is high and mem_ready is low, the request, address, write enable and write data stay unchanged in the next cycle.
- R10: A start pulse that arrives while busy is high has no effect on the running sequence or its results.
- R11: done is high for exactly one cycle, with busy low, and sp_out and bp_out carry the final values in that cycle.
- R12: After reset, busy, done and mem_req are low. No request is made while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, sampled when idle |
| frame_size | input | 16 | Bytes of local storage to reserve |
| level | input | 8 | Lexical nesting level, low 5 bits used |
| sp_in | input | 16 | Caller stack pointer |
| bp_in | input | 16 | Caller base pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 16 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready on a read |
| mem_ready | input | 1 | Access completes in a cycle where mem_req and mem_ready are high |
| sp_out | output | 16 | Resulting stack pointer |
| bp_out | output | 16 | Resulting base pointer |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Sequence in progress |

## Verification
The hardest cases to reach are those where the read and write phases of the copy loop interleave with memory stalls, and where a second start arrives in the middle of a long walk. The bench sweeps every level from 0 to 33, so it crosses the modulo-32 wrap. Each level runs under three memory models that insert zero, one or two wait cycles before ready. Stack pointers are placed so that pushes wrap through address zero. On runs with deep nesting the bench raises a rogue start, carrying different operands, a few cycles after the sequence begins.

// File: rtl/frame_entry_pkg.sv
package frame_entry_pkg;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_PUSH_BP = 3'd1,
        S_COPY_RD = 3'd2,
        S_COPY_WR = 3'd3,
        S_PUSH_FP = 3'd4,
        S_FINISH  = 3'd5
    } fe_state_e;

endpackage

// File: rtl/fe_dec2.sv
module fe_dec2 #(
    parameter int W = 16
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] val_o
);
    assign val_o = val_i - W'(2);
endmodule

// File: rtl/fe_sub.sv
module fe_sub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] diff_o
);
    assign diff_o = a_i - b_i;
endmodule

// File: rtl/frame_entry_seq.sv
module frame_entry_seq
    import frame_entry_pkg::*;
#(
    parameter int DW       = 16,
    parameter int LVL_IN_W = 8,
    parameter int LVL_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [DW-1:0]       frame_size,
    input  logic [LVL_IN_W-1:0] level,
    input  logic [DW-1:0]       sp_in,
    input  logic [DW-1:0]       bp_in,
    output logic                mem_req,
    output logic                mem_we,
    output logic [DW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_wdata,
    input  logic [DW-1:0]       mem_rdata,
    input  logic                mem_ready,
    output logic [DW-1:0]       sp_out,
    output logic [DW-1:0]       bp_out,
    output logic                done,
    output logic                busy
);

    localparam logic [LVL_W-1:0] LVL_ONE = LVL_W'(1);

    typedef struct packed {
        fe_state_e         st;
        logic [DW-1:0]     sp;
        logic [DW-1:0]     bp;
        logic [DW-1:0]     fp;
        logic [DW-1:0]     fsize;
        logic [DW-1:0]     data;
        logic [LVL_W-1:0]  lvl;
        logic [LVL_W-1:0]  cnt;
        logic              done;
    } fe_regs_t;

    fe_regs_t r_q, r_d;

    logic [DW-1:0] sp_m2, bp_m2, sp_less_fs;
    logic          lvl_unused;

    // the upper level bits are discarded on purpose (level taken mod 2^LVL_W)
    assign lvl_unused = ^level[LVL_IN_W-1:LVL_W];

    fe_dec2 #(.W(DW)) u_sp_dec (.val_i(r_q.sp), .val_o(sp_m2));
    fe_dec2 #(.W(DW)) u_bp_dec (.val_i(r_q.bp), .val_o(bp_m2));
    fe_sub  #(.W(DW)) u_fs_sub (.a_i(r_q.sp), .b_i(r_q.fsize), .diff_o(sp_less_fs));

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = sp_m2;
        mem_wdata = r_q.bp;

        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.sp    = sp_in;
                    r_d.bp    = bp_in;
                    r_d.fsize = frame_size;
                    r_d.lvl   = level[LVL_W-1:0];
                    r_d.st    = S_PUSH_BP;
                end
            end
            S_PUSH_BP: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_m2;
                mem_wdata = r_q.bp;
                if (mem_ready) begin
                    r_d.sp = sp_m2;
                    r_d.fp = sp_m2;
                    if (r_q.lvl == '0) begin
                        r_d.st = S_FINISH;
                    end else if (r_q.lvl == LVL_ONE) begin
                        r_d.st = S_PUSH_FP;
                    end else begin
                        r_d.cnt = r_q.lvl - LVL_ONE;
                        r_d.st  = S_COPY_RD;
                    end
                end
            end
            S_COPY_RD: begin
                mem_req  = 1'b1;
                mem_we   = 1'b0;
                mem_addr = bp_m2;
                if (mem_ready) begin
                    r_d.bp   = bp_m2;
                    r_d.data = mem_rdata;
                    r_d.st   = S_COPY_WR;
                end
            end
            S_COPY_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_m2;
                mem_wdata = r_q.data;
                if (mem_ready) begin
                    r_d.sp  = sp_m2;
                    r_d.cnt = r_q.cnt - LVL_ONE;
                    r_d.st  = (r_q.cnt == LVL_ONE) ? S_PUSH_FP : S_COPY_RD;
                end
            end
            S_PUSH_FP: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_m2;
                mem_wdata = r_q.fp;
                if (mem_ready) begin
                    r_d.sp = sp_m2;
                    r_d.st = S_FINISH;
                end
            end
            S_FINISH: begin
                r_d.bp   = r_q.fp;
                r_d.sp   = sp_less_fs;
                r_d.done = 1'b1;
                r_d.st   = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sp_out = r_q.sp;
    assign bp_out = r_q.bp;
    assign done   = r_q.done;
    assign busy   = (r_q.st != S_IDLE);

endmodule

// File: rtl/frame_entry_chk.sv
module frame_entry_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ready,
    input logic [DW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic [DW-1:0] mem_rdata
);

    logic          wr_seen;
    logic          rd_last;
    logic [DW-1:0] last_wa;
    logic [DW-1:0] last_rd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_seen <= 1'b0;
            rd_last <= 1'b0;
            last_wa <= '0;
            last_rd <= '0;
        end else if (start && !busy) begin
            wr_seen <= 1'b0;
            rd_last <= 1'b0;
        end else if (mem_req && mem_ready) begin
            if (mem_we) begin
                wr_seen <= 1'b1;
                last_wa <= mem_addr;
                rd_last <= 1'b0;
            end else begin
                rd_last <= 1'b1;
                last_rd <= mem_rdata;
            end
        end
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_we && wr_seen) |-> (mem_addr == DW'(last_wa - DW'(2))));

    p_copy_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_we && rd_last) |-> (mem_wdata == last_rd));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

endmodule

bind frame_entry_seq frame_entry_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
);

// File: tb/frame_entry_seq_test.sv
`timescale 1ns/1ps
module frame_entry_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] frame_size = '0;
    logic [7:0]  level = '0;
    logic [15:0] sp_in = '0;
    logic [15:0] bp_in = '0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic [15:0] sp_out, bp_out;
    logic        done, busy;

    int checks = 0;
    int errors = 0;

    logic [15:0] mem [256];
    int          wmax = 0;
    int          wcnt = 0;
    int          nwr = 0;
    int          nrd = 0;
    int          rd_bad = 0;
    logic [15:0] exp_bp0 = '0;

    always #10 clk = ~clk;

    frame_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_size(frame_size),
        .level(level), .sp_in(sp_in), .bp_in(bp_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .sp_out(sp_out), .bp_out(bp_out), .done(done), .busy(busy)
    );

    function automatic logic [15:0] pat(input logic [7:0] idx);
        return 16'hC3A5 ^ (16'(idx) * 16'd257);
    endfunction

    // memory responder: ready after wmax wait cycles
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt >= wmax) begin
                mem_ready = 1'b1;
                mem_rdata = mem[mem_addr[8:1]];
            end else begin
                wcnt++;
            end
        end
    end

    always @(posedge clk) begin
        if (mem_req && mem_ready) begin
            if (mem_we) begin
                mem[mem_addr[8:1]] = mem_wdata;
                nwr++;
            end else begin
                nrd++;
                if (mem_addr != 16'(exp_bp0 - 16'(2 * nrd))) rd_bad++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [7:0] lv, input logic [15:0] fs,
                       input logic [15:0] sp0, input int wm, input bit poke);
        int          leff, pushes, exp_rd;
        logic [15:0] bp0, exp_sp, a;
        bit          seen;
        bp0    = sp0 + 16'h0080;
        leff   = int'(lv) % 32;
        pushes = (leff == 0) ? 1 : leff + 1;
        exp_rd = (leff > 1) ? leff - 1 : 0;
        exp_sp = 16'(sp0 - 16'(2 * pushes) - fs);
        for (int i = 0; i < 256; i++) mem[i] = pat(8'(i));
        wmax = wm; nwr = 0; nrd = 0; rd_bad = 0; exp_bp0 = bp0;
        @(negedge clk);
        start = 1'b1; level = lv; frame_size = fs; sp_in = sp0; bp_in = bp0;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R10: rogue start with different operands while busy
            @(negedge clk);
            start = 1'b1; sp_in = sp0 ^ 16'h1234; bp_in = 16'h0BAD;
            level = 8'd7; frame_size = 16'h0101;
            @(negedge clk);
            start = 1'b0;
        end
        seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (done) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        chk(seen, "R11", "done seen", int'(seen), 1);
        if (!seen) return;
        chk(!busy, "R11", "busy low with done", int'(busy), 0);
        chk(sp_out == exp_sp, poke ? "R10/R7" : "R7", "sp_out", int'(sp_out), int'(exp_sp));
        chk(bp_out == 16'(sp0 - 16'd2), poke ? "R10/R6" : "R6", "bp_out",
            int'(bp_out), int'(16'(sp0 - 16'd2)));
        chk(nwr == pushes, (leff == 0) ? "R5" : "R8", "write count", nwr, pushes);
        chk(nrd == exp_rd, (leff == 0) ? "R5" : "R2", "read count", nrd, exp_rd);
        chk(rd_bad == 0, "R2", "read addresses", rd_bad, 0);
        a = 16'(sp0 - 16'd2);
        chk(mem[a[8:1]] == bp0, "R1", "old BP pushed", int'(mem[a[8:1]]), int'(bp0));
        for (int k = 1; k < leff; k++) begin
            logic [15:0] wa, ra;
            wa = 16'(sp0 - 16'd2 - 16'(2 * k));
            ra = 16'(bp0 - 16'(2 * k));
            chk(mem[wa[8:1]] == pat(ra[8:1]), "R3", "copied pointer",
                int'(mem[wa[8:1]]), int'(pat(ra[8:1])));
        end
        if (leff > 0) begin
            a = 16'(sp0 - 16'd2 - 16'(2 * leff));
            chk(mem[a[8:1]] == 16'(sp0 - 16'd2), "R4", "frame pointer pushed",
                int'(mem[a[8:1]]), int'(16'(sp0 - 16'd2)));
        end
        @(negedge clk);
        chk(!done, "R11", "done one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req, "R12", "reset state",
            int'({busy, done, mem_req}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !mem_req, "R12", "idle after reset", int'({busy, mem_req}), 0);
        for (int lv = 0; lv < 34; lv++) begin
            for (int wm = 0; wm < 3; wm++) begin
                logic [15:0] fs, sp0;
                fs  = (wm == 0) ? 16'h0000 : (wm == 1) ? 16'(lv * 16) : 16'hFFFF;
                sp0 = (lv % 3 == 0) ? 16'h4000 : (lv % 3 == 1) ? 16'h0020 : 16'hFFF0;
                run(8'(lv), fs, sp0, wm, (wm == 1) && ((lv % 32) >= 2));
            end
        end
        // R8: upper level bits ignored
        run(8'hE3, 16'h0008, 16'h4000, 1, 1'b0);
        run(8'hA0, 16'h0002, 16'h0020, 0, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule